// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block takes an operand as it sits in memory and turns it into the wide internal form that a floating-point datapath works on. The operand is up to three 32-bit words plus a three-bit type code. The type code selects a 32-bit signed integer, an IEEE single, an IEEE double, or a 96-bit extended value. The extended format carries an explicit integer bit. The result has these parts:

- a sign bit;
- a signed, unbiased exponent;
- a 96-bit mantissa whose leading one sits at bit 92, which leaves three guard bits above it;
- a sticky bit, always cleared;
- a class code.

Denormal and integer inputs are normalised inside the block by a leading-zero count and a barrel shift. A signalling NaN is made quiet on the way in. It is reported both through its class and through an exception flag.

Operands enter through a valid/ready stream and results leave through a second valid/ready stream. A single output register sits between them, so latency is one cycle. The input accepts a new operand when the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low, the result stays frozen and `in_ready` falls. A type code that is not one of the four supported formats does not produce a number. It produces a result with the illegal flag set.

Top module: `fp_unpack`

## Requirements
- R1: A transfer on the input (in_valid and in_ready high at a clock edge) appears on the output with out_valid high after that edge. in_ready is high exactly when the output register is empty or out_ready is high. While out_valid is high and out_ready is low, every output holds its value. After reset, out_valid is 0 and in_ready is 1.
- R2: The type codes are 0 = 32-bit signed integer, 1 = single, 2 = double and 3 = extended. Codes 4 to 7 (4 = byte and 5 = halfword included) are illegal. They give out_illegal = 1, class ZERO, exponent 0, mantissa 0 and out_snan = 0.
- R3: out_sign is bit 31 of in_w0 for every type, integers included. out_sticky is always 0.
- R4: The class codes are ZERO = 0, NUMBER = 1, INFINITY = 2, QNAN = 3 and SNAN = 4. An integer of 0 gives ZERO, and so does a single or double whose exponent and fraction are all zero. An extended value gives ZERO when its exponent field and both mantissa words are zero. A ZERO result carries exponent 0 and mantissa 0.
- R5: A normal single (exponent in_w0[30:23], bias 127, fraction in_w0[22:0]) or double (exponent in_w0[30:20], bias 1023, fraction {in_w0[19:0], in_w1}) gives class NUMBER. Its exponent is the field minus the bias. Its mantissa has a one at bit 92 with the fraction directly below it, the top fraction bit at bit 91.
- R6: A single or double with a zero exponent field and a non-zero fraction is a denormal. It gets exponent 1 − bias and is then normalised. The mantissa is shifted left until bit 92 is its highest set bit, and the exponent is reduced by the shift count.
- R7: A non-zero integer is converted to its magnitude (two's-complement negation when bit 31 is set). The result is normalised so that bit 92 is the leading one, and the exponent is the bit position of the magnitude's leading one. 0x80000000 gives exponent 31.
- R8: An extended operand takes its exponent field from in_w0[30:16] with bias 16383 and its 64-bit mantissa {in_w1, in_w2} at bits 92..29. A normal value has bit 92 forced to one. A zero exponent field with a non-zero mantissa gets exponent −16383, not 1 − bias, and is then normalised.
- R9: An all-ones exponent field with a zero fraction gives INFINITY, with exponent 0 and mantissa 0. For extended operands this test ignores in_w1[31]: it needs only in_w1[30:0] and in_w2 to be zero.
- R10: An all-ones exponent field with a non-zero fraction is a NaN. Its fraction bits are kept in place and its exponent is 0. If mantissa bit 91 is clear, the block sets it and reports class SNAN with out_snan = 1. Otherwise it reports QNAN with out_snan = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present on the input |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_type | input | 3 | Source format code |
| in_w0 | input | 32 | First operand word (holds the sign and exponent) |
| in_w1 | input | 32 | Second operand word |
| in_w2 | input | 32 | Third operand word |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | 18 | Signed unbiased exponent |
| out_mant | output | 96 | Mantissa, leading one at bit 92 |
| out_sticky | output | 1 | Sticky bit (always 0) |
| out_class | output | 3 | Class code |
| out_snan | output | 1 | Signalling-NaN exception flag |
| out_illegal | output | 1 | Unsupported type code |

## Verification
A wrong leading-zero count or a wrong shift direction shows up in the very next result after the operand is accepted. The leading one lands away from bit 92, and the exponent drifts by the same amount, so every denormal, integer or low-exponent extended operand exposes it one cycle after transfer. A bad class decode shows in out_class and out_snan on that same result. A quiet bit left clear shows as a NaN whose bit 91 is 0. A fault in the output register's enable shows up during a stall: the result changes while out_ready is low, or the next operand replaces a result that was never taken. Either way it appears within one cycle of the stall.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

  localparam int FP_MANT_W   = 96;
  localparam int FP_LEAD     = 92;
  localparam int FP_EXP_W    = 18;

  localparam int INT_W       = 32;
  localparam int SGL_EXPB    = 8;
  localparam int SGL_FRACB   = 23;
  localparam int DBL_EXPB    = 11;
  localparam int DBL_FRACB   = 52;
  localparam int EXT_EXPB    = 15;
  localparam int EXT_MANTB   = 64;

  typedef enum logic [2:0] {
    TY_INT  = 3'd0,
    TY_SGL  = 3'd1,
    TY_DBL  = 3'd2,
    TY_EXT  = 3'd3,
    TY_BYTE = 3'd4,
    TY_HALF = 3'd5
  } fp_type_e;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fp_class_e;

endpackage

// File: rtl/fpu_ieee_field.sv
// Decodes one IEEE interchange format (sign removed) into a pre-normalised
// exponent/mantissa/class triple. Instantiated once per supported width.
module fpu_ieee_field
  import fpu_unpack_pkg::*;
#(
  parameter int EXPB   = 8,
  parameter int FRACB  = 23,
  parameter int MANT_W = 96,
  parameter int LEAD   = 92,
  parameter int EXP_W  = 18
) (
  input  logic [EXPB+FRACB-1:0]    bits,
  output logic signed [EXP_W-1:0]  exp_o,
  output logic [MANT_W-1:0]        mant_o,
  output fp_class_e                cls_o,
  output logic                     norm_o
);
  localparam int BIAS = (1 << (EXPB - 1)) - 1;
  localparam logic signed [EXP_W-1:0] BIAS_S  = EXP_W'(BIAS);
  localparam logic signed [EXP_W-1:0] DENORM_E = EXP_W'(1 - BIAS);

  logic [EXPB-1:0]   efield;
  logic [FRACB-1:0]  frac;
  logic [MANT_W-1:0] frac_m;
  logic [MANT_W-1:0] lead_one;

  assign efield = bits[EXPB+FRACB-1:FRACB];
  assign frac   = bits[FRACB-1:0];

  always_comb begin
    frac_m = '0;
    frac_m[LEAD-1 -: FRACB] = frac;    // R5: top fraction bit just below the leading one
    lead_one = '0;
    lead_one[LEAD] = 1'b1;
  end

  always_comb begin
    exp_o  = '0;
    mant_o = '0;
    cls_o  = CLS_ZERO;
    norm_o = 1'b0;
    if (efield == '0) begin
      if (frac != '0) begin            // R6: denormal
        exp_o  = DENORM_E;
        mant_o = frac_m;
        cls_o  = CLS_NUM;
        norm_o = 1'b1;
      end
    end else if (efield == '1) begin
      if (frac == '0) begin
        cls_o = CLS_INF;               // R9
      end else begin
        cls_o  = CLS_QNAN;             // R10: quieting done downstream
        mant_o = frac_m;
      end
    end else begin
      exp_o  = $signed({{(EXP_W-EXPB){1'b0}}, efield}) - BIAS_S;
      mant_o = frac_m | lead_one;
      cls_o  = CLS_NUM;
    end
  end
endmodule

// File: rtl/fpu_fmt_split.sv
// Per-format field extraction; selects one pre-normalised result by type code.
module fpu_fmt_split
  import fpu_unpack_pkg::*;
#(
  parameter int MANT_W = 96,
  parameter int LEAD   = 92,
  parameter int EXP_W  = 18
) (
  input  logic [2:0]              ty,
  input  logic [31:0]             w0,
  input  logic [31:0]             w1,
  input  logic [31:0]             w2,
  output logic signed [EXP_W-1:0] pre_exp,
  output logic [MANT_W-1:0]       pre_mant,
  output fp_class_e               pre_cls,
  output logic                    pre_norm,
  output logic                    bad_type
);
  localparam int EXT_BIAS = (1 << (EXT_EXPB - 1)) - 1;
  localparam logic signed [EXP_W-1:0] EXT_BIAS_S = EXP_W'(EXT_BIAS);
  localparam logic signed [EXP_W-1:0] EXT_ZERO_E = EXP_W'(-EXT_BIAS);
  localparam logic signed [EXP_W-1:0] INT_E      = EXP_W'(LEAD - (MANT_W - INT_W));

  logic signed [EXP_W-1:0] s_exp, d_exp, x_exp, i_exp;
  logic [MANT_W-1:0]       s_mant, d_mant, x_mant, i_mant;
  fp_class_e               s_cls, d_cls, x_cls, i_cls;
  logic                    s_norm, d_norm, x_norm, i_norm;

  fpu_ieee_field #(.EXPB(SGL_EXPB), .FRACB(SGL_FRACB), .MANT_W(MANT_W),
                   .LEAD(LEAD), .EXP_W(EXP_W)) u_sgl (
    .bits(w0[30:0]), .exp_o(s_exp), .mant_o(s_mant), .cls_o(s_cls), .norm_o(s_norm));

  fpu_ieee_field #(.EXPB(DBL_EXPB), .FRACB(DBL_FRACB), .MANT_W(MANT_W),
                   .LEAD(LEAD), .EXP_W(EXP_W)) u_dbl (
    .bits({w0[30:0], w1}), .exp_o(d_exp), .mant_o(d_mant), .cls_o(d_cls), .norm_o(d_norm));

  // R8/R9: extended format, explicit integer bit at w1[31]
  logic [EXT_EXPB-1:0]  x_field;
  logic [EXT_MANTB-1:0] x_bits;
  logic [MANT_W-1:0]    x_placed;
  logic [MANT_W-1:0]    lead_one;

  assign x_field = w0[30:16];
  assign x_bits  = {w1, w2};

  always_comb begin
    x_placed = '0;
    x_placed[LEAD -: EXT_MANTB] = x_bits;
    lead_one = '0;
    lead_one[LEAD] = 1'b1;
  end

  always_comb begin
    x_exp  = '0;
    x_mant = '0;
    x_cls  = CLS_ZERO;
    x_norm = 1'b0;
    if (x_field == '0) begin
      if (x_bits != '0) begin
        x_exp  = EXT_ZERO_E;
        x_mant = x_placed;
        x_cls  = CLS_NUM;
        x_norm = 1'b1;
      end
    end else if (x_field == '1) begin
      if (x_bits[EXT_MANTB-2:0] == '0) begin
        x_cls = CLS_INF;
      end else begin
        x_cls  = CLS_QNAN;
        x_mant = x_placed;
      end
    end else begin
      x_exp  = $signed({{(EXP_W-EXT_EXPB){1'b0}}, x_field}) - EXT_BIAS_S;
      x_mant = x_placed | lead_one;
      x_cls  = CLS_NUM;
    end
  end

  // R7: integer magnitude loaded at the top word, exponent of its bit 0 = 0
  logic [INT_W-1:0] mag;
  assign mag = w0[31] ? (~w0 + 1'b1) : w0;

  always_comb begin
    i_mant = '0;
    i_exp  = '0;
    i_cls  = CLS_ZERO;
    i_norm = 1'b0;
    if (mag != '0) begin
      i_mant[MANT_W-1 -: INT_W] = mag;
      i_exp  = INT_E;
      i_cls  = CLS_NUM;
      i_norm = 1'b1;
    end
  end

  always_comb begin
    pre_exp  = '0;
    pre_mant = '0;
    pre_cls  = CLS_ZERO;
    pre_norm = 1'b0;
    bad_type = 1'b0;
    case (ty)
      TY_INT: begin pre_exp = i_exp; pre_mant = i_mant; pre_cls = i_cls; pre_norm = i_norm; end
      TY_SGL: begin pre_exp = s_exp; pre_mant = s_mant; pre_cls = s_cls; pre_norm = s_norm; end
      TY_DBL: begin pre_exp = d_exp; pre_mant = d_mant; pre_cls = d_cls; pre_norm = d_norm; end
      TY_EXT: begin pre_exp = x_exp; pre_mant = x_mant; pre_cls = x_cls; pre_norm = x_norm; end
      default: bad_type = 1'b1;        // R2
    endcase
  end
endmodule

// File: rtl/fpu_normalize.sv
// Leading-zero count and bidirectional shift that places the leading one at LEAD.
module fpu_normalize #(
  parameter int MANT_W = 96,
  parameter int LEAD   = 92,
  parameter int EXP_W  = 18
) (
  input  logic                    en,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [MANT_W-1:0]       mant_o
);
  localparam int LZW  = $clog2(MANT_W + 1);
  localparam int HEAD = MANT_W - 1 - LEAD;

  logic [LZW-1:0]   lz;
  logic [EXP_W-1:0] amt;

  always_comb begin
    lz = LZW'(MANT_W);
    for (int i = 0; i < MANT_W; i++) begin
      if (mant_i[i]) lz = LZW'(MANT_W - 1 - i);
    end
  end

  always_comb begin
    exp_o  = exp_i;
    mant_o = mant_i;
    amt    = '0;
    if (en && (mant_i != '0)) begin
      if (lz >= LZW'(HEAD)) begin
        amt    = EXP_W'(lz - LZW'(HEAD));
        mant_o = mant_i << (lz - LZW'(HEAD));
        exp_o  = exp_i - $signed(amt);
      end else begin
        amt    = EXP_W'(LZW'(HEAD) - lz);
        mant_o = mant_i >> (LZW'(HEAD) - lz);
        exp_o  = exp_i + $signed(amt);
      end
    end
  end
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
  import fpu_unpack_pkg::*;
#(
  parameter int MANT_W = FP_MANT_W,
  parameter int LEAD   = FP_LEAD,
  parameter int EXP_W  = FP_EXP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2:0]              in_type,
  input  logic [31:0]             in_w0,
  input  logic [31:0]             in_w1,
  input  logic [31:0]             in_w2,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_sign,
  output logic signed [EXP_W-1:0] out_exp,
  output logic [MANT_W-1:0]       out_mant,
  output logic                    out_sticky,
  output logic [2:0]              out_class,
  output logic                    out_snan,
  output logic                    out_illegal
);
  logic signed [EXP_W-1:0] pre_exp, nrm_exp;
  logic [MANT_W-1:0]       pre_mant, nrm_mant, fin_mant;
  fp_class_e               pre_cls, fin_cls;
  logic                    pre_norm, bad_type, fin_snan;
  logic signed [EXP_W-1:0] fin_exp;
  logic                    take;

  fpu_fmt_split #(.MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)) u_split (
    .ty(in_type), .w0(in_w0), .w1(in_w1), .w2(in_w2),
    .pre_exp(pre_exp), .pre_mant(pre_mant), .pre_cls(pre_cls),
    .pre_norm(pre_norm), .bad_type(bad_type));

  fpu_normalize #(.MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)) u_norm (
    .en(pre_norm), .exp_i(pre_exp), .mant_i(pre_mant),
    .exp_o(nrm_exp), .mant_o(nrm_mant));

  // R10: signalling NaNs leave the block quiet and flagged
  always_comb begin
    fin_mant = nrm_mant;
    fin_exp  = nrm_exp;
    fin_cls  = pre_cls;
    fin_snan = 1'b0;
    if (bad_type) begin
      fin_mant = '0;
      fin_exp  = '0;
      fin_cls  = CLS_ZERO;
    end else if ((pre_cls == CLS_QNAN) && !nrm_mant[LEAD-1]) begin
      fin_mant[LEAD-1] = 1'b1;
      fin_cls  = CLS_SNAN;
      fin_snan = 1'b1;
    end
  end

  // R1: single output stage, accepts when empty or draining
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_mant    <= '0;
      out_class   <= CLS_ZERO;
      out_snan    <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_sign    <= in_w0[31];          // R3
        out_exp     <= fin_exp;
        out_mant    <= fin_mant;
        out_class   <= fin_cls;
        out_snan    <= fin_snan;
        out_illegal <= bad_type;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  assign out_sticky = 1'b0;
endmodule

// File: rtl/fp_unpack_chk.sv
module fp_unpack_chk #(
  parameter int MANT_W = 96,
  parameter int LEAD   = 92,
  parameter int EXP_W  = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [2:0]              in_type,
  input logic [31:0]             in_w0,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    out_sign,
  input logic signed [EXP_W-1:0] out_exp,
  input logic [MANT_W-1:0]       out_mant,
  input logic                    out_sticky,
  input logic [2:0]              out_class,
  input logic                    out_snan,
  input logic                    out_illegal
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp)
                                && $stable(out_class) && $stable(out_sign));

  p_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_type[2] |=> out_illegal && out_class == 3'd0
                                           && out_mant == '0 && !out_snan);

  p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_sign == $past(in_w0[31]));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_sticky);

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd0 |-> out_mant == '0 && out_exp == '0);

  p_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd1 |-> out_mant[LEAD] && out_mant[MANT_W-1:LEAD+1] == '0);

  p_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_snan == (out_class == 3'd4));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == 3'd3 || out_class == 3'd4) |-> out_mant[LEAD-1]);
endmodule

bind fp_unpack fp_unpack_chk #(.MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_type(in_type), .in_w0(in_w0), .out_valid(out_valid), .out_ready(out_ready),
  .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant),
  .out_sticky(out_sticky), .out_class(out_class), .out_snan(out_snan),
  .out_illegal(out_illegal));

// File: tb/sim_fp_unpack.sv
`timescale 1ns/1ps
module sim_fp_unpack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_type = 3'd0;
  logic [31:0] in_w0 = '0, in_w1 = '0, in_w2 = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_sign, out_sticky, out_snan, out_illegal;
  logic signed [17:0] out_exp;
  logic [95:0] out_mant;
  logic [2:0] out_class;

  always #10 clk = ~clk;

  fp_unpack u0 (.*);

  typedef struct {
    logic [95:0] mant;
    int          e;
    int          cls;
    bit          sign;
    bit          snan;
    bit          ill;
  } exp_item_t;

  exp_item_t exp_q[$];
  string     tag_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  function automatic exp_item_t model(int ty, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    exp_item_t r;
    logic [95:0] raw;
    logic [63:0] fr;
    logic [31:0] mag;
    int ef, eb, fb, bias, emax, p;
    bit nan;
    r.mant = '0; r.e = 0; r.cls = 0; r.sign = a[31]; r.snan = 0; r.ill = 0;
    nan = 0;
    raw = '0;
    case (ty)
      0: begin
        mag = a[31] ? (~a + 32'd1) : a;
        if (mag != 0) begin
          p = 0;
          for (int i = 0; i < 32; i++) if (mag[i]) p = i;
          r.mant = 96'(mag) << (92 - p);
          r.e = p;
          r.cls = 1;
        end
      end
      1, 2: begin
        if (ty == 1) begin eb = 8; fb = 23; ef = int'(a[30:23]); fr = 64'(a[22:0]); end
        else begin eb = 11; fb = 52; ef = int'(a[30:20]); fr = {12'd0, a[19:0], b}; end
        bias = (1 << (eb - 1)) - 1;
        emax = (1 << eb) - 1;
        raw = 96'(fr) << (92 - fb);
        if (ef == 0) begin
          if (fr != 0) begin
            r.e = 1 - bias;
            while (!raw[92]) begin raw = raw << 1; r.e--; end
            r.mant = raw; r.cls = 1;
          end
        end else if (ef == emax) begin
          if (fr == 0) r.cls = 2; else nan = 1;
        end else begin
          raw[92] = 1'b1; r.mant = raw; r.e = ef - bias; r.cls = 1;
        end
      end
      3: begin
        ef = int'(a[30:16]);
        fr = {b, c};
        raw = 96'(fr) << 29;
        if (ef == 0) begin
          if (fr != 0) begin
            r.e = -16383;
            while (!raw[92]) begin raw = raw << 1; r.e--; end
            r.mant = raw; r.cls = 1;
          end
        end else if (ef == 32767) begin
          if (fr[62:0] == 0) r.cls = 2; else nan = 1;
        end else begin
          raw[92] = 1'b1; r.mant = raw; r.e = ef - 16383; r.cls = 1;
        end
      end
      default: r.ill = 1;
    endcase
    if (nan) begin
      if (!raw[91]) begin raw[91] = 1'b1; r.cls = 4; r.snan = 1; end
      else r.cls = 3;
      r.mant = raw;
    end
    return r;
  endfunction

  task automatic send(int ty, logic [31:0] a, logic [31:0] b, logic [31:0] c, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_type = 3'(ty); in_w0 = a; in_w1 = b; in_w2 = c;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(ty, a, b, c));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard; also drives out_ready with a stall pattern (R1)
  int cyc = 0;
  bit prev_stall = 0;
  logic [95:0] h_mant; logic signed [17:0] h_exp; logic [2:0] h_cls; logic h_sign;
  initial begin
    exp_item_t e;
    string t;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = !((cyc % 7 == 2) || (cyc % 7 == 3) || (cyc % 11 == 5));
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          checks++;
          if (!out_valid || out_mant !== h_mant || out_exp !== h_exp || out_class !== h_cls || out_sign !== h_sign) begin
            failures++;
            $display("FAIL R1 hold: valid=%0b cls=%0d exp=%0d expected held cls=%0d exp=%0d",
                     out_valid, out_class, out_exp, h_cls, h_exp);
          end
        end
        prev_stall = out_valid && !out_ready;
        h_mant = out_mant; h_exp = out_exp; h_cls = out_class; h_sign = out_sign;
        if (out_valid && out_ready) begin
          checks++;
          if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R1 unexpected output: cls=%0d expected none", out_class);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (out_class !== 3'(e.cls) || int'(out_exp) != e.e || out_mant !== e.mant ||
                out_sign !== e.sign || out_snan !== e.snan || out_illegal !== e.ill ||
                out_sticky !== 1'b0) begin
              failures++;
              $display("FAIL %s: cls=%0d exp=%0d mant=%h sign=%0b snan=%0b ill=%0b stk=%0b expected cls=%0d exp=%0d mant=%h sign=%0b snan=%0b ill=%0b stk=0",
                       t, out_class, out_exp, out_mant, out_sign, out_snan, out_illegal, out_sticky,
                       e.cls, e.e, e.mant, e.sign, e.snan, e.ill);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: got no completion expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset: out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R4 zeros (also R3 sign of negative zero)
    send(0, 32'h0, 0, 0, "R4 int zero");
    send(1, 32'h0000_0000, 0, 0, "R4 single +0");
    send(1, 32'h8000_0000, 0, 0, "R4 R3 single -0");
    send(2, 32'h0, 32'h0, 0, "R4 double zero");
    send(3, 32'h0, 32'h0, 32'h0, "R4 extended zero");
    idle();
    // R5 normals
    send(1, 32'h3F80_0000, 0, 0, "R5 single 1.0");
    send(1, 32'hC049_0FDB, 0, 0, "R5 R3 single -pi");
    send(2, 32'h3FF0_0000, 32'h0, 0, "R5 double 1.0");
    send(2, 32'h4009_21FB, 32'h5444_2D18, 0, "R5 double pi");
    send(1, 32'h0080_0000, 0, 0, "R5 single min normal");
    // R6 denormals
    send(1, 32'h0000_0001, 0, 0, "R6 single min denormal");
    send(1, 32'h8040_0000, 0, 0, "R6 single large denormal");
    send(2, 32'h0, 32'h0000_0001, 0, "R6 double min denormal");
    send(2, 32'h0008_0000, 32'h0, 0, "R6 double top denormal");
    idle(); idle();
    // R7 integers
    send(0, 32'h0000_0001, 0, 0, "R7 int 1");
    send(0, 32'hFFFF_FFFF, 0, 0, "R7 R3 int -1");
    send(0, 32'h8000_0000, 0, 0, "R7 int most negative");
    send(0, 32'h7FFF_FFFF, 0, 0, "R7 int max");
    send(0, 32'h0001_2345, 0, 0, "R7 int mid");
    send(0, 32'h1234_5678, 0, 0, "R7 int above lead");
    // R8 extended
    send(3, 32'h3FFF_0000, 32'h8000_0000, 32'h0, "R8 ext 1.0");
    send(3, 32'h4000_0000, 32'h1234_5678, 32'h9ABC_DEF0, "R8 ext unnormal forced one");
    send(3, 32'h0000_0000, 32'h4000_0000, 32'h0, "R8 ext zero-exp shift 1");
    send(3, 32'h8000_0000, 32'h8000_0000, 32'h0, "R8 ext zero-exp integer bit set");
    send(3, 32'h0000_0000, 32'h0, 32'h0000_0001, "R8 ext zero-exp deep");
    // R9 infinities
    send(1, 32'h7F80_0000, 0, 0, "R9 single +inf");
    send(2, 32'hFFF0_0000, 32'h0, 0, "R9 double -inf");
    send(3, 32'h7FFF_0000, 32'h8000_0000, 32'h0, "R9 ext inf integer bit set");
    send(3, 32'hFFFF_0000, 32'h0, 32'h0, "R9 ext inf integer bit clear");
    // R10 NaNs
    send(1, 32'h7FC0_0000, 0, 0, "R10 single qnan");
    send(1, 32'h7F80_0001, 0, 0, "R10 single snan");
    send(2, 32'h7FF0_0000, 32'h0000_0001, 0, "R10 double snan");
    send(2, 32'hFFF8_0000, 32'h0, 0, "R10 double qnan");
    send(3, 32'h7FFF_0000, 32'h8000_0000, 32'h0000_0001, "R10 ext snan");
    send(3, 32'h7FFF_0000, 32'hC000_0000, 32'h0, "R10 ext qnan");
    send(3, 32'h7FFF_0000, 32'h0000_0000, 32'h0000_0010, "R10 ext snan no integer bit");
    // R2 illegal codes
    send(4, 32'hDEAD_BEEF, 32'h1, 32'h2, "R2 byte code");
    send(5, 32'h0000_1234, 0, 0, "R2 halfword code");
    send(6, 32'h7FC0_0000, 0, 0, "R2 code 6");
    send(7, 32'h7F80_0001, 0, 0, "R2 code 7");
    send(1, 32'h4000_0000, 0, 0, "R5 single 2.0 after illegal");
    idle();

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule